// File: doc/BRIEF.md
# Multi-Channel Serial Word Concentrator

This block collects 32-bit words from eighteen independent serial lines and merges them into one time-multiplexed parallel stream. Each line has its own bit clock. A receiver in that clock's domain recovers each framed word. It checks the word's odd parity and its trailing high bits, then hands the word over to the common core clock. In the core domain, every channel owns a small holding buffer.

A frame scheduler in the core clock domain starts a new output frame every `FRAME_CYCLES` core cycles. A frame is a burst of `NUM_CH + 1` consecutive valid words on `out_data`. The burst opens with a separator word, taken from the `sep_word` input and marked by `out_sof`. One slot per channel follows, in ascending channel order. If a channel's buffer holds a word, its slot carries the oldest one. If the buffer is empty, the slot carries all zeros. Downstream logic tells the slots apart by `out_slot`. Sticky per-channel flags report parity errors and buffer overflows.

Top module: `ser_concentrator`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_sof` are 0 and every bit of `perr_flag` and `ovf_flag` is 0.
- R2: Frames start exactly `FRAME_CYCLES` core cycles apart. Each frame is `NUM_CH + 1` consecutive cycles with `out_valid` high, followed by idle cycles with `out_valid` low.
- R3: Within a frame, `out_slot` counts 0, 1, …, `NUM_CH` on consecutive cycles. Slot 0 is the separator. Slot k carries channel k-1.
- R4: Each serial word is framed as follows: one low start bit, 32 data bits least significant bit first, one parity bit, and `STOP_BITS` (2) high bits. All bits are sampled on the rising edge of that channel's `rx_clk`, and the line idles high.
- R5: When a channel's buffer is empty at the time of its slot, the slot's `out_data` is 0.
- R6: Every accepted word appears exactly once, in the first frame whose slot for that channel comes after the word has entered the buffer. Words of one channel leave in arrival order.
- R7: Parity is odd over the 32 data bits and the parity bit taken together. On a mismatch the word is still forwarded and the channel's `perr_flag` bit is set and stays set until reset.
- R8: A low bit in any stop position makes the receiver drop the word and return to searching for a start bit. The next correct word is then received normally.
- R9: Each channel holds at most `HOLD_DEPTH` (2) words. A word that arrives while the buffer is full is discarded and sets that channel's `ovf_flag` bit, which stays set until reset. The words already held are delivered unchanged.
- R10: The separator slot carries the value `sep_word` had in the cycle before `out_sof` is asserted, with `out_sof` high only in that slot. The usual setting is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for the merged stream |
| rst_n | input | 1 | Synchronous active-low reset, held for at least two serial bit clocks |
| rx_clk | input | NUM_CH | Per-channel serial bit clock |
| rx_dat | input | NUM_CH | Per-channel serial data |
| sep_word | input | WORD_W | Value sent in the separator slot |
| out_valid | output | 1 | A slot word is present on `out_data` |
| out_sof | output | 1 | This slot is the separator opening a frame |
| out_slot | output | $clog2(NUM_CH+1) | Slot index: 0 is the separator, k is channel k-1 |
| out_data | output | WORD_W | Slot word |
| perr_flag | output | NUM_CH | Sticky parity error flag per channel |
| ovf_flag | output | NUM_CH | Sticky buffer overflow flag per channel |

## Verification
The bench checks the lowest and highest channels and data patterns that have a single bit set at either end. A receiver that shifted bits the wrong way, or a scheduler with an off-by-one slot mapping, would put these words in the wrong slot or return them mirrored. It sends words on several channels at the same moment, to catch one channel's word landing in a neighbour's slot. It injects a parity error, to catch a design that drops the word or flags the wrong channel. It injects a low stop bit, to catch a receiver that forwards the broken word or stays stuck. It sends four words faster than the frames can drain them. A buffer that overwrote held words, or that kept words past its depth, would then deliver the wrong sequence. Finally, it changes the separator value, to catch a fixed or stale separator.

// File: rtl/sconc_pkg.sv
// Shared types for the serial word concentrator.
package sconc_pkg;
    // Receiver phases for one serial word.
    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_DATA = 2'd1,
        RX_PAR  = 2'd2,
        RX_STOP = 2'd3
    } rx_state_e;
endpackage

// File: rtl/ser_rx_frame.sv
// Serial word receiver, one per channel, in that channel's bit-clock domain.
// Recovers start / data (LSB first) / parity / stop framing. Each good word
// is latched together with its parity-error bit, and then a toggle flips.
// The latched pair stays stable until the next word completes, which takes
// a full serial word time. Assumes rst_n is held across several bit clocks.
module ser_rx_frame
    import sconc_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int STOP_BITS = 2
) (
    input  logic              rx_clk,
    input  logic              rst_n,
    input  logic              rx_dat,
    output logic [WORD_W-1:0] word_o,
    output logic              perr_o,
    output logic              tog_o
);
    localparam int CNT_W = $clog2(WORD_W + STOP_BITS + 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic              par_bit;

    // Framing state machine: hunt for start, shift data, take parity, check stops.
    always_ff @(posedge rx_clk) begin
        if (!rst_n) begin
            state   <= RX_HUNT;
            bit_cnt <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            word_o  <= '0;
            perr_o  <= 1'b0;
            tog_o   <= 1'b0;
        end else begin
            case (state)
                RX_HUNT: begin
                    if (!rx_dat) begin
                        state   <= RX_DATA;
                        bit_cnt <= '0;
                    end
                end
                RX_DATA: begin
                    shreg <= {rx_dat, shreg[WORD_W-1:1]};
                    if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                        state   <= RX_PAR;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    par_bit <= rx_dat;
                    state   <= RX_STOP;
                    bit_cnt <= '0;
                end
                RX_STOP: begin
                    if (!rx_dat) begin
                        state <= RX_HUNT;
                    end else if (bit_cnt == CNT_W'(STOP_BITS - 1)) begin
                        word_o <= shreg;
                        perr_o <= ~(^{shreg, par_bit});
                        tog_o  <= ~tog_o;
                        state  <= RX_HUNT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    // R8: a word is handed over only after a high final stop bit.
    assert_stop_high_R8: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (tog_o != $past(tog_o)) |-> $past(rx_dat));
endmodule

// File: rtl/word_hold.sv
// Core-domain side of one channel. It synchronises the receiver's toggle,
// captures the stable word on each toggle edge into a small FIFO, and
// keeps sticky parity and overflow flags. Assumes the receiver holds
// word_i and perr_i for many core cycles after each toggle.
module word_hold #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tog_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              perr_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] head_o,
    output logic              avail_o,
    output logic              perr_flag_o,
    output logic              ovf_flag_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [2:0]        sync_q;
    logic              push;
    logic              full;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;

    assign push    = sync_q[2] ^ sync_q[1];
    assign full    = (cnt == CNT_W'(DEPTH));
    assign avail_o = (cnt != '0);
    assign head_o  = mem[rd_ptr];

    // Two-stage synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tog_i};
    end

    // FIFO storage write; a full buffer refuses the word unless a pop frees a place.
    always_ff @(posedge clk) begin
        if (push && (!full || pop_i)) mem[wr_ptr] <= word_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push && (!full || pop_i))
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_i)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push && (!full || pop_i), pop_i})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_flag_o <= 1'b0;
            ovf_flag_o  <= 1'b0;
        end else begin
            if (push && perr_i)          perr_flag_o <= 1'b1;
            if (push && full && !pop_i)  ovf_flag_o  <= 1'b1;
        end
    end

    // R6: the scheduler only pops a buffer that holds a word.
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> avail_o);
    // R9: occupancy never exceeds the buffer depth.
    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    // R9: the overflow flag is sticky.
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_flag_o) |-> ovf_flag_o);
    // R7: the parity flag is sticky.
    assert_perr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(perr_flag_o) |-> perr_flag_o);
endmodule

// File: rtl/tdm_frame_mux.sv
// Frame scheduler. A cycle counter of period FRAME_CYCLES emits the
// separator at count 0 and channel c at count c+1, popping that channel's
// buffer when it has a word and sending zero otherwise. Outputs are
// registered. Assumes FRAME_CYCLES > NUM_CH + 1.
module tdm_frame_mux #(
    parameter int NUM_CH       = 18,
    parameter int WORD_W       = 32,
    parameter int FRAME_CYCLES = 112,
    parameter int SLOT_W       = $clog2(NUM_CH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [WORD_W-1:0]              sep_word,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  head,
    input  logic [NUM_CH-1:0]              avail,
    output logic [NUM_CH-1:0]              pop,
    output logic                           out_valid,
    output logic                           out_sof,
    output logic [SLOT_W-1:0]              out_slot,
    output logic [WORD_W-1:0]              out_data
);
    localparam int CYC_W = $clog2(FRAME_CYCLES);

    logic [CYC_W-1:0]  cyc;
    logic [WORD_W-1:0] sel_word;
    logic              in_frame;

    assign in_frame = (cyc <= CYC_W'(NUM_CH));

    // Frame period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cyc <= '0;
        else if (cyc == CYC_W'(FRAME_CYCLES - 1))  cyc <= '0;
        else                                       cyc <= cyc + 1'b1;
    end

    // Slot selection: pop the scheduled channel and pick its word or zero.
    always_comb begin
        pop      = '0;
        sel_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cyc == CYC_W'(c + 1) && avail[c]) begin
                pop[c]   = 1'b1;
                sel_word = head[c];
            end
        end
    end

    // Registered output stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_slot  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_frame;
            out_sof   <= (cyc == '0);
            out_slot  <= in_frame ? SLOT_W'(cyc) : '0;
            out_data  <= (cyc == '0) ? sep_word : sel_word;
        end
    end

    // R10: the frame start carries the separator in slot 0.
    assert_sof_sep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_slot == '0 && out_data == $past(sep_word)));
    // R3: data slots follow the previous slot directly, one index higher.
    assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> ($past(out_valid) && out_slot == $past(out_slot) + 1'b1));
    // R6: at most one buffer is drained per cycle.
    assert_pop_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
endmodule

// File: rtl/ser_concentrator.sv
// Top level: one serial receiver and one holding buffer per channel,
// built by generate, feeding a single frame scheduler.
module ser_concentrator #(
    parameter int NUM_CH       = 18,
    parameter int WORD_W       = 32,
    parameter int STOP_BITS    = 2,
    parameter int HOLD_DEPTH   = 2,
    parameter int FRAME_CYCLES = 112,
    parameter int SLOT_W       = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rx_clk,
    input  logic [NUM_CH-1:0] rx_dat,
    input  logic [WORD_W-1:0] sep_word,
    output logic              out_valid,
    output logic              out_sof,
    output logic [SLOT_W-1:0] out_slot,
    output logic [WORD_W-1:0] out_data,
    output logic [NUM_CH-1:0] perr_flag,
    output logic [NUM_CH-1:0] ovf_flag
);
    logic [NUM_CH-1:0][WORD_W-1:0] rx_word;
    logic [NUM_CH-1:0]             rx_perr;
    logic [NUM_CH-1:0]             rx_tog;
    logic [NUM_CH-1:0][WORD_W-1:0] head;
    logic [NUM_CH-1:0]             avail;
    logic [NUM_CH-1:0]             pop;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ser_rx_frame #(
            .WORD_W    (WORD_W),
            .STOP_BITS (STOP_BITS)
        ) u_rx (
            .rx_clk (rx_clk[g]),
            .rst_n  (rst_n),
            .rx_dat (rx_dat[g]),
            .word_o (rx_word[g]),
            .perr_o (rx_perr[g]),
            .tog_o  (rx_tog[g])
        );

        word_hold #(
            .WORD_W (WORD_W),
            .DEPTH  (HOLD_DEPTH)
        ) u_hold (
            .clk         (clk),
            .rst_n       (rst_n),
            .tog_i       (rx_tog[g]),
            .word_i      (rx_word[g]),
            .perr_i      (rx_perr[g]),
            .pop_i       (pop[g]),
            .head_o      (head[g]),
            .avail_o     (avail[g]),
            .perr_flag_o (perr_flag[g]),
            .ovf_flag_o  (ovf_flag[g])
        );
    end

    tdm_frame_mux #(
        .NUM_CH       (NUM_CH),
        .WORD_W       (WORD_W),
        .FRAME_CYCLES (FRAME_CYCLES),
        .SLOT_W       (SLOT_W)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sep_word  (sep_word),
        .head      (head),
        .avail     (avail),
        .pop       (pop),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_slot  (out_slot),
        .out_data  (out_data)
    );
endmodule

// File: tb/ser_concentrator_tb.sv
`timescale 1ns/1ps
module ser_concentrator_tb;
    localparam int NCH   = 18;
    localparam int FRAME = 1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sclk = 1'b0;
    logic [NCH-1:0]  rx_dat = '1;
    logic [31:0]     sep_word = 32'hFFFF_FFFF;
    logic            out_valid, out_sof;
    logic [4:0]      out_slot;
    logic [31:0]     out_data;
    logic [NCH-1:0]  perr_flag, ovf_flag;

    always #4    clk  = ~clk;
    always #12.5 sclk = ~sclk;

    ser_concentrator #(.NUM_CH(NCH), .FRAME_CYCLES(FRAME)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_clk({NCH{sclk}}), .rx_dat(rx_dat),
        .sep_word(sep_word), .out_valid(out_valid), .out_sof(out_sof),
        .out_slot(out_slot), .out_data(out_data),
        .perr_flag(perr_flag), .ovf_flag(ovf_flag));

    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_sof = -1, sof_cnt = 0, exp_slot = NCH + 1;
    int struct_err = 0, per_err = 0;
    int got_cnt [NCH];
    logic [31:0] got_word [NCH][4];
    logic [31:0] frame_buf [NCH+1];

    // Stimulus table: {channel, word}.
    localparam logic [36:0] VEC [6] = '{
        {5'd0,  32'h0000_0001}, {5'd17, 32'h8000_0000}, {5'd4, 32'hDEAD_BEEF},
        {5'd11, 32'h1234_5678}, {5'd2,  32'hFFFF_FFFF}, {5'd9, 32'h5555_AAAA}};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && out_valid) begin
            if (out_sof) begin
                if (last_sof >= 0 && cyc - last_sof != FRAME) per_err++;
                last_sof = cyc;
                sof_cnt++;
                exp_slot = 0;
            end
            if (int'(out_slot) != exp_slot) struct_err++;
            if (out_slot <= NCH) frame_buf[out_slot] = out_data;
            if (out_slot > 0 && out_slot <= NCH && out_data != 0) begin
                if (got_cnt[out_slot-1] < 4) got_word[out_slot-1][got_cnt[out_slot-1]] = out_data;
                got_cnt[out_slot-1]++;
            end
            exp_slot++;
        end else if (rst_n && exp_slot > 0 && exp_slot <= NCH) begin
            struct_err++;
            exp_slot = NCH + 1;
        end
    end

    task automatic clear_got();
        for (int c = 0; c < NCH; c++) got_cnt[c] = 0;
    endtask

    task automatic wait_frames(input int n);
        int start;
        start = sof_cnt;
        while (sof_cnt < start + n) @(negedge clk);
        repeat (25) @(negedge clk);
    endtask

    task automatic send_word(input int ch, input logic [31:0] d, input bit bad_par, input bit bad_stop);
        logic par;
        par = ~(^d) ^ bad_par;
        @(negedge sclk) rx_dat[ch] = 1'b0;
        for (int i = 0; i < 32; i++) @(negedge sclk) rx_dat[ch] = d[i];
        @(negedge sclk) rx_dat[ch] = par;
        @(negedge sclk) rx_dat[ch] = ~bad_stop;
        @(negedge sclk) rx_dat[ch] = 1'b1;
        @(negedge sclk) rx_dat[ch] = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        clear_got();
        repeat (20) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0 && out_sof == 0, "R1 valid/sof in reset", {out_valid, out_sof}, 0);
        chk(perr_flag == 0 && ovf_flag == 0, "R1 flags in reset", {perr_flag, ovf_flag}, 0);
        rst_n = 1'b1;
        wait_frames(3);
        // R2/R3/R5/R10: idle frames
        chk(per_err == 0 && sof_cnt >= 3, "R2 frame period", per_err, 0);
        chk(struct_err == 0, "R3 slot sequence", struct_err, 0);
        chk(frame_buf[0] == 32'hFFFF_FFFF, "R10 default separator", frame_buf[0], 32'hFFFF_FFFF);
        begin
            int nz;
            nz = 0;
            for (int s = 1; s <= NCH; s++) if (frame_buf[s] != 0) nz++;
            chk(nz == 0, "R5 empty slots zero", nz, 0);
        end
        // R4/R6/R3: table walk, one word per vector
        for (int v = 0; v < 6; v++) begin
            int ch, others;
            ch = int'(VEC[v][36:32]);
            clear_got();
            send_word(ch, VEC[v][31:0], 1'b0, 1'b0);
            wait_frames(2);
            chk(got_cnt[ch] == 1 && got_word[ch][0] == VEC[v][31:0], "R4 R6 word delivered once",
                {got_cnt[ch], got_word[ch][0]}, {32'd1, VEC[v][31:0]});
            others = 0;
            for (int c = 0; c < NCH; c++) if (c != ch) others += got_cnt[c];
            chk(others == 0, "R3 word only in own slot", others, 0);
        end
        // R3: simultaneous words on three channels
        clear_got();
        fork
            send_word(0,  32'hA000_0001, 1'b0, 1'b0);
            send_word(9,  32'hB000_0002, 1'b0, 1'b0);
            send_word(17, 32'hC000_0003, 1'b0, 1'b0);
        join
        wait_frames(2);
        chk(got_word[0][0] == 32'hA000_0001 && got_word[9][0] == 32'hB000_0002 &&
            got_word[17][0] == 32'hC000_0003 && got_cnt[0] + got_cnt[9] + got_cnt[17] == 3,
            "R3 concurrent channels", {got_word[0][0], got_word[17][0]}, {32'hA000_0001, 32'hC000_0003});
        // R7: parity error forwarded and flagged on its channel only
        clear_got();
        send_word(7, 32'h0F0F_0F0F, 1'b1, 1'b0);
        wait_frames(2);
        chk(got_cnt[7] == 1 && got_word[7][0] == 32'h0F0F_0F0F, "R7 bad parity forwarded",
            got_word[7][0], 32'h0F0F_0F0F);
        chk(perr_flag == 18'h00080, "R7 parity flag", perr_flag, 18'h00080);
        // R8: bad stop bit drops the word, next word received
        clear_got();
        send_word(3, 32'h1111_2222, 1'b0, 1'b1);
        send_word(3, 32'h3333_4444, 1'b0, 1'b0);
        wait_frames(2);
        chk(got_cnt[3] == 1 && got_word[3][0] == 32'h3333_4444, "R8 framing error drop",
            {got_cnt[3], got_word[3][0]}, {32'd1, 32'h3333_4444});
        // R9: four words between two pops; two kept, two dropped
        clear_got();
        wait_frames(1);
        chk(ovf_flag == 0, "R9 no overflow yet", ovf_flag, 0);
        send_word(5, 32'h5000_0001, 1'b0, 1'b0);
        send_word(5, 32'h5000_0002, 1'b0, 1'b0);
        send_word(5, 32'h5000_0003, 1'b0, 1'b0);
        send_word(5, 32'h5000_0004, 1'b0, 1'b0);
        wait_frames(3);
        chk(got_cnt[5] == 2 && got_word[5][0] == 32'h5000_0001 && got_word[5][1] == 32'h5000_0002,
            "R9 held words delivered in order", {got_cnt[5], got_word[5][1]}, {32'd2, 32'h5000_0002});
        chk(ovf_flag == 18'h00020, "R9 overflow flag", ovf_flag, 18'h00020);
        chk(perr_flag == 18'h00080, "R7 parity flag sticky", perr_flag, 18'h00080);
        // R10: programmed separator
        sep_word = 32'hA5A5_0F0F;
        wait_frames(1);
        chk(frame_buf[0] == 32'hA5A5_0F0F, "R10 programmed separator", frame_buf[0], 32'hA5A5_0F0F);
        chk(struct_err == 0 && per_err == 0, "R2 R3 structure over run", {struct_err, per_err}, 0);
        summary();
    end
endmodule